// File: doc/BRIEF.md
# Multi-Mode Planar Pixel Shifter

This block takes one 32-bit display memory word at a time and turns it into eight 4-bit pixel values, one per dot-clock enable. The word is treated as four 8-bit planes. Plane k sits in bits 8k+7 down to 8k, so plane 0 is the low byte and plane 3 the high byte. The pixel values go to a downstream attribute lookup.

Three gathering patterns are supported:
- **Planar 16-colour:** one bit is taken from every plane for each pixel.
- **Packed interleave:** two-bit pairs are taken from a pair of planes.
- **256-colour nibble:** whole nibbles are streamed out, in either of two mirrored orders.

The pattern and the nibble direction are captured when a word is loaded. The shifter raises a request while it shows its last pixel, so the feeder can load the next word in that same cycle and the pixel stream has no gap.

Top module: `pixel_shifter`

## Requirements
- R1: Synchronous active-high `rst` forces `pixelValid` = 0, `pixel` = 0 and `wordReq` = 0 on the following cycle. This holds mid-word too.
- R2: When `loadEn` is 1 at a clock edge, the next cycle shows `pixelValid` = 1 and the first pixel of `loadWord`. A load has priority over advancing and restarts a word that is part-way through.
- R3: The shifter moves to the next pixel only on an edge where `dotEn` = 1. While `dotEn` = 0 the shown pixel is held.
- R4: Each word yields exactly 8 pixels. `wordReq` is 1 exactly while the eighth pixel is shown. If that pixel is consumed without a load, `pixelValid` drops to 0. A load in that same cycle continues the stream with no gap.
- R5: Planar mode (`sel256` = 0, `selInterleave` = 0): pixel n (n = 0..7) has bit k equal to bit 7-n of plane k.
- R6: Packed mode (`sel256` = 0, `selInterleave` = 1): pixels 0-3 use planes 2 (high) and 0 (low), and pixels 4-7 use planes 3 (high) and 1 (low). For j = n mod 4, the pixel is {high[7-2j:6-2j], low[7-2j:6-2j]}.
- R7: 256-colour left order (`sel256` = 1, `dirRight` = 0): pixels are plane0[7:4], plane0[3:0], plane1[7:4], and so on, ending with plane3[3:0].
- R8: 256-colour right order (`sel256` = 1, `dirRight` = 1): pixels are plane0[3:0], plane0[7:4], and so on, ending with plane3[7:4].
- R9: `sel256` = 1 overrides `selInterleave`. `dirRight` has no effect when `sel256` = 0.
- R10: `sel256`, `selInterleave` and `dirRight` are sampled only on a load edge. Changing them mid-word does not alter the word being shown.
- R11: `pixel` reads 0 whenever `pixelValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Load strobe for `loadWord` |
| loadWord | input | 32 | Memory word, four 8-bit planes |
| dotEn | input | 1 | Dot-clock enable, consumes the shown pixel |
| sel256 | input | 1 | 256-colour nibble mode select |
| selInterleave | input | 1 | Packed interleave mode select |
| dirRight | input | 1 | Nibble order for 256-colour mode |
| pixel | output | 4 | Current pixel value |
| pixelValid | output | 1 | Pixel output holds a live value |
| wordReq | output | 1 | Eighth pixel is shown, next word may be loaded |

## Verification
The hardest case to reach from the ports is the gapless hand-off. A new word has to be loaded on exactly the edge where the eighth pixel is consumed. The stream must then continue with the new word's first pixel, without any cycle where `pixelValid` is low. The bench steps one word to its eighth pixel and checks `wordReq` there. In that same cycle it raises `loadEn` and `dotEn` together with a word in a different mode, then checks both the continuity and the new ordering.

Mid-word changes to the mode inputs are also driven, to show that they are ignored. A load arriving mid-word is driven as well, to show that it restarts the word.

// File: rtl/pixel_shifter_pkg.sv
package pixel_shifter_pkg;
  localparam int PLANE_W   = 8;
  localparam int NPLANES   = 4;
  localparam int WORD_W    = PLANE_W * NPLANES;
  localparam int PIX_W     = NPLANES;
  localparam int PIX_PER_W = PLANE_W;
  localparam int IDX_W     = $clog2(PIX_PER_W);

  typedef enum logic [1:0] {
    MODE_PLANAR    = 2'd0,
    MODE_PACKED    = 2'd1,
    MODE_NIB_LEFT  = 2'd2,
    MODE_NIB_RIGHT = 2'd3
  } shiftMode_t;

  typedef struct packed {
    logic             load;    // capture word and mode
    logic             active;  // a word is being shown
    logic [IDX_W-1:0] idx;     // pixel index within the word
  } shiftCtrl_t;
endpackage

// File: rtl/pixel_shifter_ctrl.sv
module pixel_shifter_ctrl
  import pixel_shifter_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loadEn,
  input  logic       dotEn,
  output shiftCtrl_t ctrl,
  output logic       wordReq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX_PER_W - 1);

  logic             activeQ;
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ <= 1'b0;
      idxQ    <= '0;
    end else if (loadEn) begin
      activeQ <= 1'b1;
      idxQ    <= '0;
    end else if (activeQ && dotEn) begin
      if (idxQ == LAST_IDX) activeQ <= 1'b0;
      idxQ <= idxQ + 1'b1;
    end
  end

  always_comb begin
    ctrl.load   = loadEn;
    ctrl.active = activeQ;
    ctrl.idx    = idxQ;
  end

  assign wordReq = activeQ && (idxQ == LAST_IDX);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !activeQ);

  assert_load_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (activeQ && idxQ == '0));

  assert_hold_without_dot_R3: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !dotEn) |=> ($stable(idxQ) && $stable(activeQ)));

  assert_last_pixel_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (wordReq && dotEn && !loadEn) |=> !activeQ);

  assert_step_advances_R3: assert property (@(posedge clk) disable iff (rst)
    (activeQ && dotEn && !loadEn && !wordReq) |=> (activeQ && idxQ == $past(idxQ) + 1'b1));
endmodule

// File: rtl/pixel_shifter_dp.sv
module pixel_shifter_dp
  import pixel_shifter_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  shiftCtrl_t        ctrl,
  input  logic [WORD_W-1:0] loadWord,
  input  logic              sel256,
  input  logic              selInterleave,
  input  logic              dirRight,
  output logic [PIX_W-1:0]  pixel
);
  logic [WORD_W-1:0]  wordQ;
  shiftMode_t         modeQ;
  shiftMode_t         modeIn;
  logic [PLANE_W-1:0] plane [NPLANES];

  // 256-colour select wins over interleave; direction matters only for nibbles
  always_comb begin
    if (sel256)             modeIn = dirRight ? MODE_NIB_RIGHT : MODE_NIB_LEFT;
    else if (selInterleave) modeIn = MODE_PACKED;
    else                    modeIn = MODE_PLANAR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ <= '0;
      modeQ <= MODE_PLANAR;
    end else if (ctrl.load) begin
      wordQ <= loadWord;
      modeQ <= modeIn;
    end
  end

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    assign plane[p] = wordQ[p*PLANE_W +: PLANE_W];
  end

  logic [PIX_W-1:0]   pixPlanar, pixPacked, pixNib;
  logic [PLANE_W-1:0] bitSh [NPLANES];
  logic [PLANE_W-1:0] hiSh, loSh, nibByte;
  logic [1:0]         pairSel;
  logic [2:0]         pairAmt;

  for (genvar k = 0; k < NPLANES; k++) begin : g_planar
    assign bitSh[k]     = plane[k] >> (3'd7 - ctrl.idx);
    assign pixPlanar[k] = bitSh[k][0];
  end

  assign pairSel = ctrl.idx[1:0];
  assign pairAmt = {~pairSel, 1'b0};
  assign hiSh    = plane[{1'b1, ctrl.idx[2]}] >> pairAmt;
  assign loSh    = plane[{1'b0, ctrl.idx[2]}] >> pairAmt;
  assign pixPacked = {hiSh[1:0], loSh[1:0]};

  assign nibByte = plane[ctrl.idx[2:1]];

  always_comb begin
    if (modeQ == MODE_NIB_RIGHT) pixNib = ctrl.idx[0] ? nibByte[7:4] : nibByte[3:0];
    else                         pixNib = ctrl.idx[0] ? nibByte[3:0] : nibByte[7:4];
  end

  always_comb begin
    pixel = '0;
    if (ctrl.active) begin
      case (modeQ)
        MODE_PLANAR: pixel = pixPlanar;
        MODE_PACKED: pixel = pixPacked;
        default:     pixel = pixNib;
      endcase
    end
  end

  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> ($stable(modeQ) && $stable(wordQ)));

  assert_256_overrides_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && sel256) |=> (modeQ == MODE_NIB_LEFT || modeQ == MODE_NIB_RIGHT));

  assert_idle_pixel_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !ctrl.active |-> (pixel == '0));
endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter
  import pixel_shifter_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        loadEn,
  input  logic [31:0] loadWord,
  input  logic        dotEn,
  input  logic        sel256,
  input  logic        selInterleave,
  input  logic        dirRight,
  output logic [3:0]  pixel,
  output logic        pixelValid,
  output logic        wordReq
);
  shiftCtrl_t ctrl;

  pixel_shifter_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .loadEn  (loadEn),
    .dotEn   (dotEn),
    .ctrl    (ctrl),
    .wordReq (wordReq)
  );

  pixel_shifter_dp u_dp (
    .clk           (clk),
    .rst           (rst),
    .ctrl          (ctrl),
    .loadWord      (loadWord),
    .sel256        (sel256),
    .selInterleave (selInterleave),
    .dirRight      (dirRight),
    .pixel         (pixel)
  );

  assign pixelValid = ctrl.active;
endmodule

// File: tb/pixel_shifter_tb.sv
module pixel_shifter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic [31:0] loadWord = '0;
  logic        dotEn = 1'b0;
  logic        sel256 = 1'b0;
  logic        selInterleave = 1'b0;
  logic        dirRight = 1'b0;
  logic [3:0]  pixel;
  logic        pixelValid;
  logic        wordReq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pixel_shifter u_dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadWord(loadWord), .dotEn(dotEn),
    .sel256(sel256), .selInterleave(selInterleave), .dirRight(dirRight),
    .pixel(pixel), .pixelValid(pixelValid), .wordReq(wordReq)
  );

  // {sel256, selInterleave, dirRight, word, eight expected pixels, first in the top nibble}
  localparam int NVEC = 8;
  localparam logic [66:0] VEC [NVEC] = '{
    {3'b000, 32'h67452301, 32'h0CA00CAF},  // R5 planar
    {3'b001, 32'h80000001, 32'h80000001},  // R5 planar, direction ignored (R9)
    {3'b010, 32'h67452301, 32'h40454A4F},  // R6 packed
    {3'b011, 32'h80000001, 32'h00018000},  // R6 packed, direction ignored (R9)
    {3'b100, 32'h67452301, 32'h01234567},  // R7 left nibbles
    {3'b101, 32'h67452301, 32'h10325476},  // R8 right nibbles
    {3'b110, 32'h67452301, 32'h01234567},  // R9 override of interleave
    {3'b111, 32'h80000001, 32'h10000008}   // R9 override, right order
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [2:0] m);
    if (m[2] && m[1]) return "R9";
    if (m[2]) return m[0] ? "R8" : "R7";
    return m[1] ? "R6" : "R5";
  endfunction

  task automatic loadOne(input logic [2:0] m, input logic [31:0] w);
    @(negedge clk);
    loadEn = 1'b1; loadWord = w; dotEn = 1'b0;
    {sel256, selInterleave, dirRight} = m;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(pixelValid), 0);
    chk("R1 pixel", 32'(pixel), 0);
    chk("R1 req", 32'(wordReq), 0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      loadOne(VEC[v][66:64], VEC[v][63:32]);
      chk("R2 valid after load", 32'(pixelValid), 1);
      for (int i = 0; i < 8; i++) begin
        dotEn = 1'b1;
        chk(modeTag(VEC[v][66:64]), 32'(pixel), 32'(VEC[v][31 - 4*i -: 4]));
        chk("R4 req", 32'(wordReq), (i == 7) ? 1 : 0);
        @(negedge clk);
      end
      dotEn = 1'b0;
      chk("R4 valid drops", 32'(pixelValid), 0);
      chk("R11 idle pixel", 32'(pixel), 0);
    end

    // R3 hold while dotEn is low (right order, first pixel 1, second 0)
    loadOne(3'b101, 32'h67452301);
    for (int i = 0; i < 3; i++) begin
      chk("R3 hold", 32'(pixel), 1);
      @(negedge clk);
    end
    dotEn = 1'b1;
    @(negedge clk);
    dotEn = 1'b0;
    chk("R3 advance", 32'(pixel), 0);

    // R10 mode inputs changed mid-word are ignored
    loadOne(3'b000, 32'h67452301);
    dotEn = 1'b1;
    repeat (2) @(negedge clk);
    sel256 = 1'b1; dirRight = 1'b1;
    dotEn = 1'b0;
    @(negedge clk);
    chk("R10 planar kept", 32'(pixel), 32'hA);
    dotEn = 1'b1;
    @(negedge clk);
    dotEn = 1'b0;
    chk("R10 planar kept next", 32'(pixel), 0);

    // R2 load mid-word restarts, with priority over dotEn
    loadEn = 1'b1; dotEn = 1'b1; loadWord = 32'h67452301;
    sel256 = 1'b1; selInterleave = 1'b0; dirRight = 1'b1;
    @(negedge clk);
    loadEn = 1'b0; dotEn = 1'b0;
    chk("R2 restart first", 32'(pixel), 1);
    chk("R2 restart valid", 32'(pixelValid), 1);

    // R4 gapless hand-off to a word in another mode
    loadOne(3'b100, 32'h67452301);
    dotEn = 1'b1;
    repeat (7) @(negedge clk);
    chk("R4 req at eighth", 32'(wordReq), 1);
    chk("R7 eighth pixel", 32'(pixel), 7);
    loadEn = 1'b1; loadWord = 32'h80000001; dirRight = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    chk("R4 gapless valid", 32'(pixelValid), 1);
    chk("R4 gapless first", 32'(pixel), 1);
    chk("R4 req cleared", 32'(wordReq), 0);
    @(negedge clk);
    chk("R8 second after hand-off", 32'(pixel), 0);

    // R1 reset mid-word
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; dotEn = 1'b0;
    chk("R1 mid valid", 32'(pixelValid), 0);
    chk("R1 mid pixel", 32'(pixel), 0);
    chk("R1 mid req", 32'(wordReq), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule